// File: doc/BRIEF.md
# Serial Port Interrupt Identification Unit

This block sits inside a serial port controller and turns four interrupt causes into one request line and a readable identification code. The causes are a receiver line error, received data ready, transmit holding register empty and a modem status change. Each arrives from the neighbouring logic as a one-cycle event pulse. The block latches each pulse in its own flag. A four-bit enable register decides which latched flags may raise the request. When several enabled flags are set, the identification register reports the one with the highest priority.

Software reaches the block through a byte-wide register port with an address, a read strobe and a write strobe. The block also watches accesses to registers that other parts of the controller own, because those accesses clear a flag: reading the receive buffer, writing the transmit holding register, reading line status and reading modem status. An input from the line control logic selects the divisor bank. While it is set, offset 1 and offset 0 belong to the baud divisor, so those accesses neither reach the enable register nor clear a flag.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the enable register reads 0x00, the identification register reads 0x01 and `irq` is low.
- R2: With `dlab` low, a write to offset 1 stores `wdata[3:0]` into the enable register. A read of offset 1 returns `{4'b0, enable}`. Bit 0 enables receive-ready, bit 1 transmit-empty, bit 2 line error and bit 3 modem change. A read of offset 2 returns `{5'b0, id}` whatever `dlab` is. A read of any other offset returns 0x00.
- R3: With `dlab` high, a write to offset 1 leaves the enable register unchanged and a read of offset 1 returns 0x00. Reads and writes of offset 0 clear no flag.
- R4: An event sets its flag whether or not that source is enabled. A set flag whose enable bit is 0 affects neither `irq` nor the identification code. Setting the enable bit later makes the pending flag visible.
- R5: Identification bits [2:1] name the highest-priority enabled pending source: 11 line error, then 10 receive-ready, then 01 transmit-empty, then 00 modem change.
- R6: Identification bit 0 is 0 exactly while an enabled source is pending, and `irq` is its inverse. `irq` falls in the cycle after the clock edge that clears the last enabled flag.
- R7: A read of offset 0 with `dlab` low clears the receive-ready flag.
- R8: A read of offset 5 clears the line error flag.
- R9: The transmit-empty flag clears on a write of offset 0 with `dlab` low. It also clears on a read of offset 2 while the identification code is 010. A read of offset 2 that returns any other code leaves it set.
- R10: A read of offset 6 clears the modem change flag.
- R11: An event that arrives in the same cycle as its clearing access leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for offsets 1 and 2, otherwise zero |
| dlab | input | 1 | Divisor bank select from line control |
| ev_rx_ready | input | 1 | Received data ready event |
| ev_tx_empty | input | 1 | Transmit holding register empty event |
| ev_line_err | input | 1 | Receiver line error event |
| ev_modem_chg | input | 1 | Modem status change event |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that `irq` and identification bit 0 always agree and that an enabled line error always wins the code. They also check that each clearing access empties its flag on the next edge unless an event arrives with it, that an event always sets its flag, and that divisor-bank writes never move the enable register. Some behaviour depends on a sequence of accesses, and only the bench's scenarios can show it. This covers draining all four sources one by one in priority order, a pending flag hidden by a mask and revealed when the mask is set, and an identification read that clears transmit-empty only when that source is the one reported.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC    = 4;
  localparam int IDX_RX  = 0;
  localparam int IDX_TX  = 1;
  localparam int IDX_LS  = 2;
  localparam int IDX_MS  = 3;

  localparam logic [2:0] ID_NONE = 3'b001;
  localparam logic [2:0] ID_LS   = 3'b110;
  localparam logic [2:0] ID_RX   = 3'b100;
  localparam logic [2:0] ID_TX   = 3'b010;
  localparam logic [2:0] ID_MS   = 3'b000;

  // fixed priority: line error > rx ready > tx empty > modem change
  function automatic logic [2:0] ident(input logic [NSRC-1:0] act);
    if (act[IDX_LS])      return ID_LS;
    else if (act[IDX_RX]) return ID_RX;
    else if (act[IDX_TX]) return ID_TX;
    else if (act[IDX_MS]) return ID_MS;
    else                  return ID_NONE;
  endfunction
endpackage

// File: rtl/irq_src_flag.sv
module irq_src_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // an event is never lost, even against a coinciding clear
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] act_i,
  output logic [2:0]      id_o,
  output logic            req_o
);
  always_comb begin
    id_o  = ident(act_i);
    req_o = |act_i;
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int AW        = 3,
  parameter int OFS_DATA  = 0,
  parameter int OFS_IEN   = 1,
  parameter int OFS_IID   = 2,
  parameter int OFS_LSTAT = 5,
  parameter int OFS_MSTAT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          dlab,
  input  logic          ev_rx_ready,
  input  logic          ev_tx_empty,
  input  logic          ev_line_err,
  input  logic          ev_modem_chg,
  output logic          irq
);
  localparam int PADW = 8 - NSRC;

  logic [NSRC-1:0] ien_q, flag_q, act, set_v, clr_v;
  logic [2:0]      id;

  // named access events
  logic rd_rbr, wr_thr, wr_ien, rd_iid, rd_lsr, rd_msr;
  assign rd_rbr = rd_en && (addr == AW'(OFS_DATA))  && !dlab;
  assign wr_thr = wr_en && (addr == AW'(OFS_DATA))  && !dlab;
  assign wr_ien = wr_en && (addr == AW'(OFS_IEN))   && !dlab;
  assign rd_iid = rd_en && (addr == AW'(OFS_IID));
  assign rd_lsr = rd_en && (addr == AW'(OFS_LSTAT));
  assign rd_msr = rd_en && (addr == AW'(OFS_MSTAT));

  always_ff @(posedge clk) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= wdata[NSRC-1:0];
  end

  always_comb begin
    set_v         = '0;
    set_v[IDX_RX] = ev_rx_ready;
    set_v[IDX_TX] = ev_tx_empty;
    set_v[IDX_LS] = ev_line_err;
    set_v[IDX_MS] = ev_modem_chg;
    clr_v         = '0;
    clr_v[IDX_RX] = rd_rbr;
    clr_v[IDX_TX] = wr_thr || (rd_iid && id == ID_TX);
    clr_v[IDX_LS] = rd_lsr;
    clr_v[IDX_MS] = rd_msr;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irq_src_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[i]),
      .clr_i  (clr_v[i]),
      .flag_o (flag_q[i])
    );
  end

  assign act = flag_q & ien_q;

  irq_prio_enc u_enc (
    .act_i (act),
    .id_o  (id),
    .req_o (irq)
  );

  always_comb begin
    rdata = 8'h00;
    if (addr == AW'(OFS_IEN) && !dlab) rdata = {{PADW{1'b0}}, ien_q};
    else if (addr == AW'(OFS_IID))     rdata = {5'b0, id};
  end

  assert_ien_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(OFS_IEN) && dlab) |=> $stable(ien_q));
  assert_req_matches_id_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !id[0]);
  assert_line_err_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[IDX_LS] && ien_q[IDX_LS]) |-> id == ID_LS);
  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
  assert_rx_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rbr && !ev_rx_ready) |=> !flag_q[IDX_RX]);
  assert_ls_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !ev_line_err) |=> !flag_q[IDX_LS]);
  assert_tx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_thr && !ev_tx_empty) |=> !flag_q[IDX_TX]);
  assert_ms_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && !ev_modem_chg) |=> !flag_q[IDX_MS]);
endmodule

// File: tb/tb_uart_irq_id.sv
`timescale 1ns/1ps
module tb_uart_irq_id;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] addr;
  logic       rd_en, wr_en, dlab;
  logic [7:0] wdata, rdata;
  logic       ev_rx_ready, ev_tx_empty, ev_line_err, ev_modem_chg;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  uart_irq_id dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .dlab(dlab),
    .ev_rx_ready(ev_rx_ready), .ev_tx_empty(ev_tx_empty),
    .ev_line_err(ev_line_err), .ev_modem_chg(ev_modem_chg), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // bit order {modem, line, tx, rx}
  task automatic pulse(input logic [3:0] e);
    @(negedge clk);
    {ev_modem_chg, ev_line_err, ev_tx_empty, ev_rx_ready} = e;
    @(negedge clk);
    {ev_modem_chg, ev_line_err, ev_tx_empty, ev_rx_ready} = 4'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {7'b0, irq}, 8'h00);
    reg_rd(3'd1, rv); chk("R1 enable", rv, 8'h00);
    reg_rd(3'd2, rv); chk("R1 id", rv, 8'h01);
  endtask

  task automatic t_enable_reg();
    reg_wr(3'd1, 8'hFF); reg_rd(3'd1, rv); chk("R2 enable readback", rv, 8'h0F);
    reg_rd(3'd3, rv); chk("R2 unowned offset", rv, 8'h00);
    reg_wr(3'd1, 8'h05); reg_rd(3'd1, rv); chk("R2 enable pattern", rv, 8'h05);
  endtask

  task automatic t_dlab();
    reg_wr(3'd1, 8'h0F);
    dlab = 1'b1;
    reg_wr(3'd1, 8'h00);
    reg_rd(3'd1, rv); chk("R3 offset1 read in divisor bank", rv, 8'h00);
    pulse(4'b0001);
    reg_rd(3'd0, rv);
    reg_wr(3'd0, 8'h55);
    reg_rd(3'd2, rv); chk("R2 id readable in divisor bank", rv, 8'h04);
    dlab = 1'b0;
    reg_rd(3'd1, rv); chk("R3 enable kept", rv, 8'h0F);
    reg_rd(3'd0, rv);
    chk("R7 rx cleared", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_mask();
    reg_wr(3'd1, 8'h00);
    pulse(4'b0001);
    chk("R4 masked irq", {7'b0, irq}, 8'h00);
    reg_rd(3'd2, rv); chk("R4 masked id", rv, 8'h01);
    reg_wr(3'd1, 8'h01);
    chk("R4 unmasked irq", {7'b0, irq}, 8'h01);
    reg_rd(3'd2, rv); chk("R4 unmasked id", rv, 8'h04);
    pulse(4'b0100);
    reg_rd(3'd2, rv); chk("R4 masked line err hidden", rv, 8'h04);
    reg_rd(3'd0, rv);
    chk("R6 irq falls on clear", {7'b0, irq}, 8'h00);
    reg_rd(3'd5, rv);
  endtask

  task automatic t_priority();
    reg_wr(3'd1, 8'h0F);
    pulse(4'b1111);
    chk("R6 irq all", {7'b0, irq}, 8'h01);
    reg_rd(3'd2, rv); chk("R5 line err first", rv, 8'h06);
    reg_rd(3'd5, rv); chk("R2 lstat read data", rv, 8'h00);
    reg_rd(3'd2, rv); chk("R8 then rx", rv, 8'h04);
    reg_rd(3'd0, rv);
    reg_rd(3'd2, rv); chk("R7 then tx", rv, 8'h02);
    reg_rd(3'd2, rv); chk("R9 id read cleared tx", rv, 8'h00);
    chk("R6 irq modem pending", {7'b0, irq}, 8'h01);
    reg_rd(3'd6, rv);
    reg_rd(3'd2, rv); chk("R10 modem cleared", rv, 8'h01);
    chk("R6 irq idle", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_tx_rules();
    pulse(4'b0110);
    reg_rd(3'd2, rv); chk("R9 id shows line err", rv, 8'h06);
    reg_rd(3'd5, rv);
    reg_rd(3'd2, rv); chk("R9 tx kept after other id read", rv, 8'h02);
    pulse(4'b0010);
    reg_wr(3'd0, 8'hA5);
    reg_rd(3'd2, rv); chk("R9 holding write clears tx", rv, 8'h01);
  endtask

  task automatic t_coincide();
    @(negedge clk); addr = 3'd0; rd_en = 1'b1; ev_rx_ready = 1'b1;
    @(negedge clk); rd_en = 1'b0; ev_rx_ready = 1'b0;
    chk("R11 set beats clear", {7'b0, irq}, 8'h01);
    reg_rd(3'd2, rv); chk("R11 id", rv, 8'h04);
    reg_rd(3'd0, rv);
    chk("R7 final clear", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; rd_en = 0; wr_en = 0; wdata = '0; dlab = 0;
    {ev_modem_chg, ev_line_err, ev_tx_empty, ev_rx_ready} = 4'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable_reg();
    t_dlab();
    t_mask();
    t_priority();
    t_tx_rules();
    t_coincide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule